// File: doc/BRIEF.md
# Speculative Load Address Table

This block keeps a small record of loads that the compiler moved above earlier stores. When such a load issues, the pipeline writes the load's destination register number and memory address into the table. Every committed store then presents its address. A store that falls in the same 8-byte granule as a recorded load removes that record, because the load may have read stale data.

At the load's original place in program order, a check names the destination register. One cycle later the table answers whether the load is still good or must be re-executed. A register with no record answers "re-execute". This covers a register that was never loaded speculatively, one whose record a store removed, and one whose record was pushed out by capacity. The failure is therefore always on the safe side.

The table is fully associative, with eight entries by default. A new load to a register that already has a record replaces that record and counts as the newest. When all entries are in use, a load to a new register displaces the oldest record. Within one cycle the store is applied first, then the check looks up its register, then the new load is written.

Top module: `spec_load_table`

## Requirements
- R1: While reset is asserted and afterwards, `rsp_valid` is 0. The table starts empty, so a check issued right after reset answers `rsp_reexec`=1.
- R2: After a load records register T, a check on T with no conflicting store in between answers `rsp_reexec`=0.
- R3: A store whose address bits [ADDR_W-1:3] equal those of a recorded load removes that record, so a later check on it answers 1. A store whose bits [ADDR_W-1:3] differ leaves the record in place.
- R4: One store removes every record in its granule in the same cycle, however many registers share that granule.
- R5: A second load to the same register replaces the first record. After that, only stores to the new granule affect that register.
- R6: A check on a register that has no record answers `rsp_reexec`=1.
- R7: When all ENTRIES records are in use, a load to a register without a record displaces the record written longest ago. A reload refreshes a record's age. Only the displaced register's check then answers 1.
- R8: When a store and a check arrive in the same cycle, the store's removal is applied before the check looks up its register.
- R9: When a load and a check name the same register in the same cycle, the check sees the table as it was before that load.
- R10: A store arriving in the same cycle as a load does not affect the record that load writes. The same store still removes older matching records.
- R11: A check does not remove a record, so repeated checks on a valid record keep answering 0.
- R12: `rsp_valid` is 1 in exactly the cycle after each cycle with `chk_en`=1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Record a speculative load this cycle |
| ld_reg | input | REG_W | Destination register of the load |
| ld_addr | input | ADDR_W | Byte address read by the load |
| st_en | input | 1 | A store commits this cycle |
| st_addr | input | ADDR_W | Byte address written by the store |
| chk_en | input | 1 | Check a register this cycle |
| chk_reg | input | REG_W | Register being checked |
| rsp_valid | output | 1 | Check answer present (one cycle after chk_en) |
| rsp_reexec | output | 1 | 1: load must be re-executed; 0: load data is good |

## Verification
The hardest case to reach is a full table whose records have mixed ages and several records in one granule. This is the only case where eviction order and multi-record removal interact. A register reloaded in the middle of a sequence must shift the ages of only the younger records.

Directed sequences fill all eight entries, refresh one record, and then force an eviction. The bench also places several registers in one granule before a single store. A long random phase then draws from twelve registers and sixteen granules. In this phase the table stays close to full and stores often hit several records, while a queue-based model predicts each answer.

// File: rtl/slt_pkg.sv
package slt_pkg;

  typedef enum logic [1:0] {
    FILL_NONE,
    FILL_REUSE,
    FILL_FREE,
    FILL_EVICT
  } fill_kind_e;

endpackage

// File: rtl/slt_match.sv
module slt_match #(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 7,
  parameter int LINE_W  = 45
) (
  input  logic [ENTRIES-1:0][REG_W-1:0]  ent_reg,
  input  logic [ENTRIES-1:0][LINE_W-1:0] ent_line,
  input  logic [LINE_W-1:0]              st_line,
  input  logic [REG_W-1:0]               chk_reg,
  input  logic [REG_W-1:0]               ld_reg,
  output logic [ENTRIES-1:0]             st_eq,
  output logic [ENTRIES-1:0]             chk_eq,
  output logic [ENTRIES-1:0]             ld_eq
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign st_eq[i]  = (ent_line[i] == st_line);
    assign chk_eq[i] = (ent_reg[i] == chk_reg);
    assign ld_eq[i]  = (ent_reg[i] == ld_reg);
  end

endmodule

// File: rtl/slt_age.sv
module slt_age #(
  parameter int ENTRIES = 8,
  parameter int RW      = 3
) (
  input  logic [ENTRIES-1:0][RW-1:0] rank_in,
  input  logic [ENTRIES-1:0]         kill,
  output logic [ENTRIES-1:0][RW-1:0] rank_out
);

  // Number of removed records younger than the given rank
  function automatic logic [RW-1:0] younger_removed(
    input logic [ENTRIES-1:0][RW-1:0] r,
    input logic [ENTRIES-1:0]         k,
    input logic [RW-1:0]              mine
  );
    logic [RW-1:0] n;
    n = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (k[j] && (r[j] < mine)) n = n + 1'b1;
    end
    return n;
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rank
    assign rank_out[i] = rank_in[i] - younger_removed(rank_in, kill, rank_in[i]);
  end

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc
  import slt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int RW      = 3
) (
  input  logic [ENTRIES-1:0]         alive,
  input  logic [ENTRIES-1:0]         reuse,
  input  logic [ENTRIES-1:0][RW-1:0] rank_mid,
  output logic [ENTRIES-1:0]         slot,
  output fill_kind_e                 kind,
  output logic [RW:0]                age_limit
);

  localparam logic [RW:0]   ALL_AGE    = (RW+1)'(ENTRIES);
  localparam logic [RW-1:0] OLDEST_AGE = RW'(ENTRIES - 1);

  always_comb begin
    slot      = '0;
    kind      = FILL_NONE;
    age_limit = ALL_AGE;
    if (|reuse) begin
      kind = FILL_REUSE;
      slot = reuse;
      for (int i = 0; i < ENTRIES; i++) begin
        if (reuse[i]) age_limit = {1'b0, rank_mid[i]};
      end
    end else if (!(&alive)) begin
      kind = FILL_FREE;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (!alive[i]) begin
          slot    = '0;
          slot[i] = 1'b1;
        end
      end
    end else begin
      kind      = FILL_EVICT;
      age_limit = {1'b0, OLDEST_AGE};
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank_mid[i] == OLDEST_AGE) slot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int REG_W     = 7,
  parameter int ADDR_W    = 48,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_en,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              rsp_valid,
  output logic              rsp_reexec
);

  localparam int RW     = $clog2(ENTRIES);
  localparam int LINE_W = ADDR_W - GRAN_LOG2;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GRAN_LOG2];
  endfunction

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][REG_W-1:0]  reg_q;
  logic [ENTRIES-1:0][LINE_W-1:0] line_q;
  logic [ENTRIES-1:0][RW-1:0]     rank_q;

  logic [ENTRIES-1:0]             st_eq, chk_eq, ld_eq;
  logic [ENTRIES-1:0][RW-1:0]     rank_mid;
  logic [ENTRIES-1:0]             slot;
  fill_kind_e                     kind;
  logic [RW:0]                    age_limit;

  // Named internal events
  logic [ENTRIES-1:0] store_kill;
  logic [ENTRIES-1:0] alive;
  logic [ENTRIES-1:0] chk_live;
  logic [ENTRIES-1:0] ld_reuse;
  logic [ENTRIES-1:0] fill;
  logic               chk_found;
  logic               evict_fire;

  slt_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .LINE_W(LINE_W)) i_match (
    .ent_reg (reg_q),
    .ent_line(line_q),
    .st_line (line_of(st_addr)),
    .chk_reg (chk_reg),
    .ld_reg  (ld_reg),
    .st_eq   (st_eq),
    .chk_eq  (chk_eq),
    .ld_eq   (ld_eq)
  );

  assign store_kill = {ENTRIES{st_en}} & st_eq & valid_q;
  assign alive      = valid_q & ~store_kill;
  assign chk_live   = chk_eq & alive;
  assign chk_found  = |chk_live;
  assign ld_reuse   = ld_eq & alive;

  slt_age #(.ENTRIES(ENTRIES), .RW(RW)) i_age (
    .rank_in (rank_q),
    .kill    (store_kill),
    .rank_out(rank_mid)
  );

  slt_alloc #(.ENTRIES(ENTRIES), .RW(RW)) i_alloc (
    .alive    (alive),
    .reuse    (ld_reuse),
    .rank_mid (rank_mid),
    .slot     (slot),
    .kind     (kind),
    .age_limit(age_limit)
  );

  assign fill       = {ENTRIES{ld_en}} & slot;
  assign evict_fire = ld_en && (kind == FILL_EVICT);

  logic [ENTRIES-1:0]         valid_d;
  logic [ENTRIES-1:0][RW-1:0] rank_d;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      valid_d[i] = alive[i] | fill[i];
      if (fill[i])
        rank_d[i] = '0;
      else if (ld_en && alive[i] && ({1'b0, rank_mid[i]} < age_limit))
        rank_d[i] = rank_mid[i] + 1'b1;
      else
        rank_d[i] = rank_mid[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      rank_q     <= '0;
      reg_q      <= '0;
      line_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_reexec <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      rank_q     <= rank_d;
      rsp_valid  <= chk_en;
      rsp_reexec <= chk_en && !chk_found;
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill[i]) begin
          reg_q[i]  <= ld_reg;
          line_q[i] <= line_of(ld_addr);
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic dup_reg;
  always_comb begin
    dup_reg = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (valid_q[i] && valid_q[j] && (reg_q[i] == reg_q[j])) dup_reg = 1'b1;
  end

  p_unique_reg_r5: assert property (@(posedge clk) disable iff (!rst_n) !dup_reg);

  p_evict_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_fire |-> (&alive));

  p_slot_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> $onehot(slot));

  p_miss_reexec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !chk_found) |=> (rsp_valid && rsp_reexec));

  p_rsp_follows_chk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |=> rsp_valid);

  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !rsp_valid);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    p_rank_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[i] |-> (int'(rank_q[i]) < $countones(valid_q)));

    p_store_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (store_kill[i] && !fill[i]) |=> !valid_q[i]);

    p_check_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_live[i] && !fill[i]) |=> valid_q[i]);
  end

endmodule

// File: tb/test_spec_load_table.sv
`timescale 1ns/1ps
module test_spec_load_table;

  localparam int E  = 8;
  localparam int RG = 7;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0, st_en = 1'b0, chk_en = 1'b0;
  logic [RG-1:0] ld_reg = '0, chk_reg = '0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0;
  logic          rsp_valid, rsp_reexec;

  always #2.5 clk = ~clk;

  spec_load_table i_spec_load_table (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_en(st_en), .st_addr(st_addr),
    .chk_en(chk_en), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_reexec(rsp_reexec)
  );

  typedef struct { logic [RG-1:0] r; logic [AW-4:0] g; } rec_t;
  rec_t model[$];   // oldest first
  int compared = 0, mismatched = 0;

  task automatic compare(input bit ev, input bit er, input string req);
    compared++;
    if (rsp_valid !== ev || rsp_reexec !== er) begin
      mismatched++;
      $display("FAIL %s: rsp_valid=%0b rsp_reexec=%0b expected %0b %0b at %0t",
               req, rsp_valid, rsp_reexec, ev, er, $time);
    end
  endtask

  // One cycle: drive at negedge, update model, compare after the edge
  task automatic step(input bit ld, input int lr, input longint la,
                      input bit st, input longint sa,
                      input bit ck, input int cr, input string req);
    bit found;
    ld_en = ld; ld_reg = RG'(lr); ld_addr = AW'(la);
    st_en = st; st_addr = AW'(sa);
    chk_en = ck; chk_reg = RG'(cr);
    if (st)
      for (int i = model.size() - 1; i >= 0; i--)
        if (model[i].g == st_addr[AW-1:3]) model.delete(i);
    found = 0;
    foreach (model[i]) if (model[i].r == chk_reg) found = 1;
    if (ld) begin
      for (int i = model.size() - 1; i >= 0; i--)
        if (model[i].r == ld_reg) model.delete(i);
      if (model.size() == E) void'(model.pop_front());
      model.push_back('{r: ld_reg, g: ld_addr[AW-1:3]});
    end
    @(posedge clk); #1;
    compare(ck, ck && !found, req);
    @(negedge clk);
  endtask

  task automatic load(input int r, input longint a, input string req);
    step(1, r, a, 0, 0, 0, 0, req);
  endtask
  task automatic store(input longint a, input string req);
    step(0, 0, 0, 1, a, 0, 0, req);
  endtask
  task automatic check(input int r, input string req);
    step(0, 0, 0, 0, 0, 1, r, req);
  endtask
  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(0, 0, "R1");
    rst_n = 1'b1;
    idle("R1");
    check(5, "R1");                       // empty table
    idle("R12");

    load(1, 'h1000, "R2");
    check(1, "R2");
    idle("R12");

    store('h1007, "R3");                   // same granule
    check(1, "R3");
    load(2, 'h2000, "R3");
    store('h2008, "R3");                   // next granule
    check(2, "R3");

    load(3, 'h3000, "R4");
    load(4, 'h3004, "R4");
    store('h3003, "R4");
    check(3, "R4");
    check(4, "R4");

    load(5, 'h4000, "R5");
    load(5, 'h5000, "R5");
    store('h4000, "R5");
    check(5, "R5");
    store('h5000, "R5");
    check(5, "R5");

    check(99, "R6");

    for (int k = 0; k < 8; k++) load(10 + k, 'h10000 + k * 'h100, "R7");
    load(10, 'h20000, "R7");               // refresh age of reg 10
    load(18, 'h21000, "R7");               // evicts reg 11
    check(11, "R7");
    check(10, "R7");
    check(12, "R7");
    check(18, "R7");

    load(20, 'h6000, "R8");
    step(0, 0, 0, 1, 'h6000, 1, 20, "R8");

    step(1, 21, 'h6100, 0, 0, 1, 21, "R9"); // check sees pre-load state
    check(21, "R9");
    step(1, 10, 'h6200, 0, 0, 1, 10, "R9");
    check(10, "R9");

    load(23, 'h7000, "R10");
    step(1, 22, 'h7000, 1, 'h7000, 0, 0, "R10");
    check(22, "R10");
    check(23, "R10");

    check(22, "R11");
    check(22, "R11");

    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom_range(0, 7));
      step(op[0], int'($urandom_range(0, 11)), longint'($urandom_range(0, 127)),
           op[1], longint'($urandom_range(0, 127)),
           op[2], int'($urandom_range(0, 11)), "R7");
    end
    idle("R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule